// File: doc/BRIEF.md
# Stretched Chip Reset with Clock Re-lock Restart

This block produces the chip-wide active-low reset. While the external active-low reset pin is low, the output reset is held low asynchronously. When the pin is released, the release passes through a short synchronizer. After that, a down-counter keeps reset asserted for a fixed stretch interval. The interval is long enough for the clock generators to settle.

A one-cycle write strobe from the clock-tuning configuration register restarts the same stretch at any time. This lets the clock generators re-lock under a new setting while the rest of the chip is held in reset.

The output comes straight from a flop. Downstream logic sees a clean reset that changes only at a clock edge, or on the asynchronous assertion. When the output goes high, every block behind it starts from its default state.

Top module: `rst_stretch_top`

## Requirements
- R1: While `ext_rst_n` is 0, `rst_out_n` is 0. This takes effect asynchronously, without waiting for a clock edge. Pulling `ext_rst_n` low during a stretch cancels the stretch, and a fresh full stretch follows the next release.
- R2: The release of `ext_rst_n` passes through `SYNC_STAGES` flops (default 2) before counting begins. The counter holds its full value until the synchronized release arrives.
- R3: Number the first rising clock edge on which `ext_rst_n` is 1 as edge 1. Then `rst_out_n` is 0 after edges 1 through `SYNC_STAGES`+S, and goes to 1 on edge `SYNC_STAGES`+S+1, where S is the stretch length in cycles.
- R4: S equals (`CLK_FREQ_HZ`/1,000,000)×`STRETCH_US` when `STRETCH_OVR` is 0, and equals `STRETCH_OVR` otherwise.
- R5: When `tune_wr`=1 is sampled at edge T while the block is idle, `rst_out_n` goes to 0 after edge T+1, stays 0 through edge T+S, and returns to 1 on edge T+S+1.
- R6: When `tune_wr`=1 is sampled at an edge T during a running stretch, the counter reloads to the full S. `rst_out_n` then returns to 1 on edge T+S+1, measured from the last such strobe.
- R7: `tune_wr` sampled while `ext_rst_n` is 0, or before the synchronized release arrives, has no effect. The release timing of R3 is unchanged.
- R8: `rst_out_n` is 0 in the cycle after any cycle in which the internal reset is active. Once at 1, it stays at 1 until a new strobe or a new external reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| tune_wr | input | 1 | One-cycle strobe from the clock-tuning register write, active high |
| rst_out_n | output | 1 | Stretched chip reset, active low, registered |

## Verification
The bench counts edges from the release and samples exactly one cycle before and one cycle after the expected rising edge of the output. This catches a design whose synchronizer depth or counter terminal value is off by one, because that design releases a cycle early or late.

A second strobe in the middle of a stretch catches a design that ignores retriggers or adds the new interval to the old one. Strobes held across the synchronizer window catch a design that lets an early strobe shift the release.

Dropping the external reset mid-stretch catches a synchronous-only assertion and a counter that resumes instead of reloading. A second instance that derives its stretch from frequency and time checks the length computation.

// File: rtl/rst_stretch_pkg.sv
package rst_stretch_pkg;

   // Stretch length in clock cycles; a nonzero override wins.
   function automatic int unsigned stretch_cycles(input int unsigned freq_hz,
                                                  input int unsigned dur_us,
                                                  input int unsigned override_cyc);
      if (override_cyc != 0)
         return override_cyc;
      return (freq_hz / 1_000_000) * dur_us;
   endfunction

   // Counter width able to hold the value n (at least one bit).
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((n >> w) != 0)
         w++;
      return w;
   endfunction

endpackage

// File: rtl/rst_sync_chain.sv
// Release synchronizer: asynchronous assert, synchronous deassert.
module rst_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic sync_n
);

   logic [STAGES-1:0] stage_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n)
                  stage_q[0] <= 1'b0;
               else
                  stage_q[0] <= 1'b1;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n)
                  stage_q[i] <= 1'b0;
               else
                  stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/rst_stretch_cnt.sv
// Down-counter holding the internal reset for CYCLES after release/strobe.
module rst_stretch_cnt #(
   parameter int unsigned CYCLES = 20,
   parameter int unsigned CW     = 5
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          go_n,
   input  logic          reload,
   output logic          busy,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] FULL = CW'(CYCLES);

   generate
      if (CYCLES == 0) begin : g_no_stretch
         assign cnt  = '0;
         assign busy = !go_n;
      end else begin : g_counter
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)
               cnt_q <= FULL;
            else if (!go_n)
               cnt_q <= FULL;
            else if (reload)
               cnt_q <= FULL;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign cnt  = cnt_q;
         assign busy = !go_n || (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/rst_out_reg.sv
// Output flop so the chip reset never glitches on combinational terms.
module rst_out_reg (
   input  logic clk,
   input  logic arst_n,
   input  logic hold,
   output logic rst_n_o
);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         rst_n_o <= 1'b0;
      else
         rst_n_o <= !hold;
   end

endmodule

// File: rtl/rst_stretch_top.sv
module rst_stretch_top #(
   parameter int unsigned CLK_FREQ_HZ = 100_000_000,
   parameter int unsigned STRETCH_US  = 500,
   parameter int unsigned STRETCH_OVR = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic ext_rst_n,
   input  logic tune_wr,
   output logic rst_out_n
);

   import rst_stretch_pkg::*;

   localparam int unsigned CYCLES = stretch_cycles(CLK_FREQ_HZ, STRETCH_US, STRETCH_OVR);
   localparam int unsigned CW     = cnt_width(CYCLES);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (STRETCH_OVR == 0 && CLK_FREQ_HZ < 1_000_000) begin : g_bad_freq
         $error("CLK_FREQ_HZ below 1 MHz needs STRETCH_OVR");
      end
   endgenerate

   logic          sync_n;
   logic          busy;
   logic [CW-1:0] cnt_q;

   rst_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (ext_rst_n),
      .sync_n (sync_n)
   );

   rst_stretch_cnt #(.CYCLES(CYCLES), .CW(CW)) u_cnt (
      .clk    (clk),
      .arst_n (ext_rst_n),
      .go_n   (sync_n),
      .reload (tune_wr),
      .busy   (busy),
      .cnt    (cnt_q)
   );

   rst_out_reg u_out (
      .clk     (clk),
      .arst_n  (ext_rst_n),
      .hold    (busy),
      .rst_n_o (rst_out_n)
   );

endmodule

// File: rtl/rst_stretch_chk.sv
module rst_stretch_chk #(
   parameter int unsigned CYCLES = 20,
   parameter int unsigned CW     = 5
) (
   input logic          clk,
   input logic          ext_rst_n,
   input logic          tune_wr,
   input logic          rst_out_n,
   input logic          sync_n,
   input logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] FULL = CW'(CYCLES);

   assert_async_hold_R1: assert property (@(posedge clk)
      !ext_rst_n |-> !rst_out_n);

   assert_release_gate_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(rst_out_n) |-> ($past(sync_n) && $past(cnt) == '0));

   assert_strobe_asserts_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (tune_wr && sync_n) |-> ##2 !rst_out_n);

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
      cnt <= FULL);

   assert_held_low_R8: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (!sync_n || cnt != '0) |=> !rst_out_n);

   generate
      if (CYCLES > 0) begin : g_cnt_props
         assert_sync_load_R2: assert property (@(posedge clk) disable iff (!ext_rst_n)
            $rose(sync_n) |-> cnt == FULL);

         assert_reload_R6: assert property (@(posedge clk) disable iff (!ext_rst_n)
            (tune_wr && sync_n) |=> cnt == FULL);

         assert_count_step_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
            (sync_n && !tune_wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
      end
   endgenerate

endmodule

bind rst_stretch_top rst_stretch_chk #(.CYCLES(CYCLES), .CW(CW)) u_chk (
   .clk       (clk),
   .ext_rst_n (ext_rst_n),
   .tune_wr   (tune_wr),
   .rst_out_n (rst_out_n),
   .sync_n    (sync_n),
   .cnt       (cnt_q)
);

// File: tb/rst_stretch_top_tb_top.sv
`timescale 1ns/1ps
module rst_stretch_top_tb_top;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic ext_rst_n = 1'b0;
   logic tune_wr   = 1'b0;
   logic out_a, out_b;

   // S = 20 by override
   rst_stretch_top #(.STRETCH_OVR(20), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .ext_rst_n(ext_rst_n), .tune_wr(tune_wr), .rst_out_n(out_a));

   // S = 4 MHz * 5 us = 20 derived (R4)
   rst_stretch_top #(.CLK_FREQ_HZ(4_000_000), .STRETCH_US(5)) dut2_i (
      .clk(clk), .ext_rst_n(ext_rst_n), .tune_wr(tune_wr), .rst_out_n(out_b));

   typedef struct {
      int    c;
      logic  v;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc    = 0;
   int   checks = 0;
   int   errors = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic expect_at(input int c, input logic v, input string tag);
      exp_t e;
      e.c = c; e.v = v; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic nedge(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe();
      tune_wr = 1'b1;
      @(negedge clk);
      tune_wr = 1'b0;
   endtask

   task automatic drain();
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   // Monitor: sample 2 ns after each rising edge
   always begin
      @(posedge clk);
      #2;
      while (q.size() > 0 && q[0].c <= cyc) begin
         exp_t e;
         e = q.pop_front();
         if (e.c < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s: sample missed, actual cycle %0d expected cycle %0d", e.tag, cyc, e.c);
         end else begin
            check({e.tag, " dut_i"},  out_a, e.v);
            check({e.tag, " dut2_i"}, out_b, e.v);
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int r, t;
      // R1: reset state
      nedge(3);
      check("R1 reset dut_i", out_a, 1'b0);
      check("R1 reset dut2_i", out_b, 1'b0);

      // R2 / R3 / R8: release timing, N=2, S=20
      r = cyc;
      ext_rst_n = 1'b1;
      expect_at(r + 1, 1'b0, "R2");
      expect_at(r + 2, 1'b0, "R2");
      expect_at(r + 22, 1'b0, "R3");
      expect_at(r + 23, 1'b1, "R3");
      expect_at(r + 24, 1'b1, "R8");
      expect_at(r + 30, 1'b1, "R8");
      drain();

      // R5: strobe while idle
      nedge(2);
      t = cyc;
      expect_at(t + 1, 1'b1, "R5");
      expect_at(t + 2, 1'b0, "R5");
      expect_at(t + 21, 1'b0, "R5");
      expect_at(t + 22, 1'b1, "R5");
      strobe();
      drain();

      // R6: retrigger mid-stretch
      nedge(2);
      t = cyc;
      expect_at(t + 22, 1'b0, "R6");
      expect_at(t + 29, 1'b0, "R6");
      expect_at(t + 30, 1'b1, "R6");
      strobe();
      nedge(7);
      strobe();
      drain();

      // R7: strobes during external reset and synchronizer window
      nedge(2);
      ext_rst_n = 1'b0;
      #1;
      check("R1 async dut_i", out_a, 1'b0);
      check("R1 async dut2_i", out_b, 1'b0);
      nedge(1);
      strobe();
      nedge(2);
      r = cyc;
      ext_rst_n = 1'b1;
      tune_wr   = 1'b1;
      expect_at(r + 22, 1'b0, "R7");
      expect_at(r + 23, 1'b1, "R7");
      nedge(2);
      tune_wr = 1'b0;
      drain();

      // R1: external reset mid-stretch reloads full interval
      nedge(2);
      strobe();
      nedge(5);
      ext_rst_n = 1'b0;
      #1;
      check("R1 midstretch dut_i", out_a, 1'b0);
      check("R1 midstretch dut2_i", out_b, 1'b0);
      nedge(3);
      r = cyc;
      ext_rst_n = 1'b1;
      expect_at(r + 22, 1'b0, "R1");
      expect_at(r + 23, 1'b1, "R1");
      drain();

      finish_run();
   end

endmodule